// File: doc/BRIEF.md
# Page Write Buffer with In-Page Address Wrap

This block gathers the data bytes of one write transfer into a page-sized staging store. It tracks the byte address where the next byte lands. A start address is loaded first. Its upper bits pick a page of `PAGE_BYTES` contiguous bytes aligned to a multiple of `PAGE_BYTES`, and its low bits give the first offset, which need not be aligned. Each accepted byte is stored at the current offset, and the offset then moves forward by one. Only the offset bits count. Past the last byte of the page the offset returns to the first byte of the same page and never carries into the page number. A transfer longer than one page therefore overwrites bytes it staged earlier.

A commit strobe, raised by the bus front end when the transfer stops, starts a sweep over every offset of the page in ascending order. For each offset that received a byte, the block drives one array write (address, data, enable) in its own cycle. When the sweep ends, the block forgets which offsets were written and becomes idle again. While the sweep runs, `busy` is high and every other input is ignored. A single-byte write is the same sequence with one byte staged.

Top module: `page_wr_buf`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0.
- R2: A `ld_en` pulse while idle selects page `ld_addr[16:7]` and sets the current offset to `ld_addr[6:0]`, which may be any value 0 to 127. The next accepted byte is written to exactly `ld_addr`.
- R3: A `byte_vld` pulse while idle, with `ld_en` low, stages `byte_data` at the current offset and advances the offset by one.
- R4: When a byte is staged at offset 127, the next byte lands at offset 0 of the same page, and the page bits do not change.
- R5: If more than 128 bytes are staged before a commit, each offset is written to the array only once, carrying the last byte staged there.
- R6: During a commit, the array port issues one write per staged offset, one per cycle. Writes go in ascending offset order, and `arr_addr` = {page, offset}. Unstaged offsets produce no write.
- R7: A `commit` pulse while idle raises `busy` in the next cycle. `busy` stays high for exactly 129 cycles and then falls. The staged-offset record is then empty, so an immediate second commit writes nothing.
- R8: While `busy` is high, `ld_en`, `byte_vld` and `commit` have no effect. The offset continues from where it stood before the commit.
- R9: `arr_we` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load start address |
| ld_addr | input | 17 | Start byte address |
| byte_vld | input | 1 | Data byte present |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | End of transfer; start writing staged bytes |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 17 | Array byte address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Commit sweep in progress |

## Verification
The bench targets several corner cases:
- A start address two bytes below a page end, where a design that carries into the page number would write to the next page.
- A transfer of 130 bytes, where a broken overwrite path would emit an offset twice or keep the older data.
- A commit with nothing staged, and a commit straight after another, which catch a staged-offset record that is not cleared.
- Load, byte and commit pulses injected mid-sweep. A design that obeys them would move the page, add a stray write, or lengthen or restart the sweep.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SCAN = 2'd1,
    SEQ_LAST = 2'd2
  } seq_st_t;
endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
  parameter int ADDR_W = 17,
  parameter int OFF_W  = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [ADDR_W-1:0]       load_addr,
  input  logic                    step,
  output logic [ADDR_W-OFF_W-1:0] page_o,
  output logic [OFF_W-1:0]        off_o
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_o <= '0;
      off_o  <= '0;
    end else if (load) begin
      page_o <= load_addr[ADDR_W-1:OFF_W];
      off_o  <= load_addr[OFF_W-1:0];
    end else if (step) begin
      off_o  <= off_o + OFF_W'(1);
    end
  end

  a_r4_page_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> page_o == $past(page_o));
endmodule

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              clr,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o
);
  logic [DATA_W-1:0]     store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_off] <= wr_data;
    rd_data_o <= store[rd_off];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask     <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      if (clr) mask <= '0;
      else if (wr_en) mask[wr_off] <= 1'b1;
      rd_vld_o <= rd_en & mask[rd_off];
    end
  end

  a_r7_mask_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> mask == '0);
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !clr |=> mask == $past(mask));
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             scan_en_o,
  output logic [OFF_W-1:0] scan_off_o,
  output logic [OFF_W-1:0] out_off_o,
  output logic             clr_o,
  output logic             busy_o
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  seq_st_t st;

  assign scan_en_o = (st == SEQ_SCAN);
  assign clr_o     = (st == SEQ_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SEQ_IDLE;
      scan_off_o <= '0;
      out_off_o  <= '0;
      busy_o     <= 1'b0;
    end else begin
      out_off_o <= scan_off_o;
      case (st)
        SEQ_IDLE: if (start) begin
          st         <= SEQ_SCAN;
          scan_off_o <= '0;
          busy_o     <= 1'b1;
        end
        SEQ_SCAN: begin
          scan_off_o <= scan_off_o + OFF_W'(1);
          if (scan_off_o == LAST_OFF) st <= SEQ_LAST;
        end
        SEQ_LAST: begin
          st     <= SEQ_IDLE;
          busy_o <= 1'b0;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  a_r7_busy_after_commit: assert property (@(posedge clk) disable iff (rst)
    start && !busy_o |=> busy_o);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy_o && !clr_o |=> busy_o);
endmodule

// File: rtl/page_wr_buf.sv
module page_wr_buf #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              commit,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  cur_off, scan_off, out_off;
  logic              scan_en, clr;
  logic              take_load, take_byte, take_commit;

  assign take_load   = ld_en & ~busy;
  assign take_byte   = byte_vld & ~busy & ~ld_en;
  assign take_commit = commit & ~busy;

  pwb_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
    .clk(clk), .rst(rst), .load(take_load), .load_addr(ld_addr),
    .step(take_byte), .page_o(page), .off_o(cur_off)
  );

  pwb_latch #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_latch (
    .clk(clk), .rst(rst), .wr_en(take_byte), .wr_off(cur_off),
    .wr_data(byte_data), .rd_en(scan_en), .rd_off(scan_off), .clr(clr),
    .rd_data_o(arr_data), .rd_vld_o(arr_we)
  );

  pwb_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_seq (
    .clk(clk), .rst(rst), .start(take_commit), .scan_en_o(scan_en),
    .scan_off_o(scan_off), .out_off_o(out_off), .clr_o(clr), .busy_o(busy)
  );

  assign arr_addr = {page, out_off};

  a_r9_we_only_busy: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
  a_r6_same_page: assert property (@(posedge clk) disable iff (rst)
    arr_we && $past(arr_we) |-> arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W]));
  a_r6_ascending: assert property (@(posedge clk) disable iff (rst)
    arr_we && $past(arr_we) |-> arr_addr[OFF_W-1:0] == $past(arr_addr[OFF_W-1:0]) + OFF_W'(1));
endmodule

// File: tb/tb_page_wr_buf.sv
module tb_page_wr_buf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [16:0] ld_addr = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        commit = 1'b0;
  logic        arr_we;
  logic [16:0] arr_addr;
  logic [7:0]  arr_data;
  logic        busy;

  always #4 clk = ~clk;

  page_wr_buf dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .commit(commit),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data), .busy(busy)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0] m_mem [128];
  logic       m_msk [128];
  logic [9:0] m_page = '0;
  logic [6:0] m_off = '0;

  // start address, byte count, first data value
  localparam logic [33:0] VEC [5] = '{
    {17'h00000, 9'd1,   8'h11},
    {17'h00085, 9'd5,   8'h40},
    {17'h1FF7E, 9'd4,   8'hA0},
    {17'h0013C, 9'd130, 8'h01},
    {17'h00100, 9'd128, 8'h80}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [16:0] a);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a;
    @(negedge clk);
    ld_en = 1'b0;
    m_page = a[16:7]; m_off = a[6:0];
  endtask

  task automatic send_byte(input logic [7:0] d);
    byte_vld = 1'b1; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
    m_mem[m_off] = d; m_msk[m_off] = 1'b1;
    m_off = m_off + 7'd1;
  endtask

  // Commit and compare every array write; optionally inject pulses mid-sweep.
  task automatic do_commit(input string req, input logic inject);
    int busy_n = 0;
    int exp_off = 0;
    int wr_n = 0;
    int exp_n = 0;
    for (int i = 0; i < 128; i++) if (m_msk[i]) exp_n++;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    chk(busy == 1'b1, "R7 busy rises", int'(busy), 1);
    while (busy) begin
      busy_n++;
      if (arr_we) begin
        while (exp_off < 128 && !m_msk[exp_off]) exp_off++;
        chk({m_page, 7'(exp_off)} == arr_addr, {req, " R6 addr"}, int'(arr_addr),
            int'({m_page, 7'(exp_off)}));
        chk(arr_data == m_mem[exp_off], {req, " R6 data"}, int'(arr_data), int'(m_mem[exp_off]));
        exp_off++;
        wr_n++;
      end
      if (inject && busy_n == 5) begin
        ld_en = 1'b1; ld_addr = 17'h00005;
        byte_vld = 1'b1; byte_data = 8'hEE; commit = 1'b1;
      end else begin
        ld_en = 1'b0; byte_vld = 1'b0; commit = 1'b0;
      end
      @(negedge clk);
      if (busy_n > 400) break;
    end
    chk(busy_n == 129, {req, " R7 busy length"}, busy_n, 129);
    chk(wr_n == exp_n, {req, " R6 write count"}, wr_n, exp_n);
    @(negedge clk);
    chk(busy == 1'b0, {req, " R8 no restart"}, int'(busy), 0);
    for (int i = 0; i < 128; i++) m_msk[i] = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin m_mem[i] = '0; m_msk[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(arr_we == 1'b0, "R1 arr_we", int'(arr_we), 0);

    // R7: empty commit after reset writes nothing
    do_commit("R7 empty", 1'b0);

    // R2 R3 R4 R5 R6: vector table
    for (int v = 0; v < 5; v++) begin
      logic [16:0] a;
      logic [8:0]  n;
      logic [7:0]  s;
      {a, n, s} = VEC[v];
      do_load(a);
      for (int b = 0; b < int'(n); b++) send_byte(s + 8'(b));
      do_commit($sformatf("R2 R3 R4 R5 vec%0d", v), 1'b0);
    end

    // R7: back-to-back commit finds record empty
    do_commit("R7 second commit", 1'b0);

    // R8: pulses during sweep ignored; offset carries on afterwards
    do_load(17'h0A0F0);
    send_byte(8'h5A);
    send_byte(8'h5B);
    do_commit("R8 injected", 1'b1);
    send_byte(8'h77);
    do_commit("R8 offset kept", 1'b0);

    // R3: load and byte in same cycle, byte dropped
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 17'h00200; byte_vld = 1'b1; byte_data = 8'h99;
    @(negedge clk);
    ld_en = 1'b0; byte_vld = 1'b0;
    m_page = 10'h004; m_off = 7'd0;
    send_byte(8'h31);
    do_commit("R3 load wins", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule